// File: doc/BRIEF.md
# Descriptor table register unit

This unit holds the two registers that locate the descriptor tables used in segmented address translation. The global table register is a single 40-bit word: a 24-bit base and a 16-bit limit. It is written and read back whole. The local table register has two parts. The first is a 16-bit selector that software can see and read back. The second is a 40-bit base/limit copy that software can never read.

Loading the local register works indirectly. The unit first checks the selector. If the selector passes, the unit fetches the 8-byte entry it names from the global table over a simple request/acknowledge read port. It then checks that the entry is a present local-table descriptor. Only after all of that does it commit the selector, base and limit together. Any rejection raises a one-cycle fault and leaves the previous contents untouched. A null selector is accepted at once and marks the local table as unusable. The current bases and limits of both tables go continuously to a translation unit.

Top module: `dtr_unit`

## Requirements
- R1: After reset, the global base and limit are zero, the selector read-back is zero, the local base and limit are zero, and `ldt_valid_o`, `busy_o`, `done_o`, `fault_o` and `mem_req_o` are all low.
- R2: A `gdt_load_i` pulse writes `gdt_data_i` whole, packed as {base[23:0], limit[15:0]}. From the next cycle the same word reads back on `gdt_data_o`, and the two fields appear on `gdt_base_o` and `gdt_limit_o`.
- R3: A load whose selector has bit 2 set (the table bit, which must be 0 for the global table) raises `fault_o` in the next cycle. No fetch is issued and the selector, local base, limit and valid are unchanged.
- R4: Let the index be selector bits [15:3]. A non-null load with {index, 3'b111} greater than the global limit faults in the next cycle, with no fetch and no change of state. An index whose last byte equals the limit is accepted.
- R5: An accepted non-null load raises `mem_req_o` in the next cycle, with `mem_addr_o` = global base + index*8. The request and the address stay steady until `mem_ack_i` is seen.
- R6: In the 64-bit descriptor returned on `mem_rdata_i`, the type field is bits [43:40]. Any value other than 2 makes the load fault, with state unchanged.
- R7: The present bit, descriptor bit 47, must be 1. Otherwise the load faults, with state unchanged.
- R8: A descriptor that passes both checks updates the selector, local limit (descriptor bits [15:0]) and local base (bits [39:16]) in the same clock. It also sets `ldt_valid_o` and pulses `done_o` for one cycle.
- R9: A null selector (index 0, table bit 0, any RPL) is committed in the next cycle without a fetch. It pulses `done_o`, clears `ldt_valid_o`, and zeroes the local base and limit.
- R10: `ldt_sel_o` returns exactly the last committed selector, RPL bits included. It is the only readable part of the local register.
- R11: While `busy_o` is high, `ldt_load_i` is ignored. The fetch in flight completes with its own selector, and no second fetch follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gdt_load_i | input | 1 | Write the global table register |
| gdt_data_i | input | 40 | Global word {base, limit} to write |
| gdt_data_o | output | 40 | Global word read-back |
| ldt_load_i | input | 1 | Start a local register load |
| ldt_sel_i | input | 16 | Selector to load |
| ldt_sel_o | output | 16 | Committed selector read-back |
| busy_o | output | 1 | Descriptor fetch in progress |
| done_o | output | 1 | One-cycle pulse: load committed |
| fault_o | output | 1 | One-cycle pulse: load rejected |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 24 | Descriptor byte address |
| mem_ack_i | input | 1 | Read data valid, ends the request |
| mem_rdata_i | input | 64 | Descriptor returned |
| gdt_base_o | output | 24 | Global table base to translation |
| gdt_limit_o | output | 16 | Global table limit to translation |
| ldt_base_o | output | 24 | Local table base to translation |
| ldt_limit_o | output | 16 | Local table limit to translation |
| ldt_valid_o | output | 1 | Local table usable |

## Verification
The hardest case to reach is a second load request that arrives while a descriptor fetch is still outstanding. The port-side memory must hold back its acknowledge for that to happen. The bench plays the memory from inside each test task, so it can keep `mem_ack_i` low for several cycles, pulse `ldt_load_i` with a different selector during that window, and only then return the descriptor. It then checks that the first selector is committed and that no second request appears. The exact limit boundary is reached by choosing a global limit whose last legal index ends precisely on it, and loading that index and the next one.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int unsigned DESC_W    = 64;
  localparam int unsigned ACC_W     = 8;
  localparam int unsigned ENTRY_SH  = 3;  // 8-byte entries
  localparam int unsigned TYPE_W    = 4;

  typedef enum logic {ST_IDLE, ST_FETCH} dtr_state_e;
endpackage

// File: rtl/dtr_gdt_reg.sv
module dtr_gdt_reg #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LIM_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W+LIM_W-1:0] wdata_i,
  output logic [ADDR_W+LIM_W-1:0] rdata_o,
  output logic [ADDR_W-1:0]       base_o,
  output logic [LIM_W-1:0]        limit_o
);
  logic [ADDR_W+LIM_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (we_i) word_q <= wdata_i;
  end

  assign rdata_o = word_q;
  assign base_o  = word_q[ADDR_W+LIM_W-1:LIM_W];
  assign limit_o = word_q[LIM_W-1:0];
endmodule

// File: rtl/dtr_sel_check.sv
module dtr_sel_check #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LIM_W  = 16,
  parameter int unsigned IDX_W  = 13
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              ti_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [LIM_W-1:0]  gdt_limit_i,
  output logic              is_null_o,
  output logic              ti_err_o,
  output logic              lim_err_o,
  output logic [ADDR_W-1:0] addr_o
);
  import dtr_pkg::*;
  localparam int unsigned OFS_W = IDX_W + ENTRY_SH;
  localparam int unsigned CMP_W = (OFS_W > LIM_W) ? OFS_W : LIM_W;

  logic [OFS_W-1:0] last_byte;
  assign last_byte = {idx_i, {ENTRY_SH{1'b1}}};

  assign ti_err_o  = ti_i;
  assign is_null_o = !ti_i && (idx_i == '0);
  assign lim_err_o = CMP_W'(last_byte) > CMP_W'(gdt_limit_i);
  assign addr_o    = gdt_base_i + ADDR_W'({idx_i, {ENTRY_SH{1'b0}}});
endmodule

// File: rtl/dtr_desc_chk.sv
module dtr_desc_chk #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned LIM_W    = 16,
  parameter logic [3:0]  LDT_TYPE = 4'd2
) (
  input  logic [dtr_pkg::DESC_W-1:0] desc_i,
  output logic                       ok_o,
  output logic [ADDR_W-1:0]          base_o,
  output logic [LIM_W-1:0]           limit_o
);
  import dtr_pkg::*;
  localparam int unsigned ACC_LSB = ADDR_W + LIM_W;

  logic [ACC_W-1:0] acc;
  logic             unused_hi;

  assign acc       = desc_i[ACC_LSB +: ACC_W];
  assign unused_hi = ^desc_i[DESC_W-1:ACC_LSB+ACC_W];
  assign ok_o      = acc[ACC_W-1] && (acc[TYPE_W-1:0] == LDT_TYPE);
  assign base_o    = desc_i[ACC_LSB-1:LIM_W];
  assign limit_o   = desc_i[LIM_W-1:0];
endmodule

// File: rtl/dtr_unit.sv
module dtr_unit #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned LIM_W    = 16,
  parameter int unsigned SEL_W    = 16,
  parameter logic [3:0]  LDT_TYPE = 4'd2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       gdt_load_i,
  input  logic [ADDR_W+LIM_W-1:0]    gdt_data_i,
  output logic [ADDR_W+LIM_W-1:0]    gdt_data_o,
  input  logic                       ldt_load_i,
  input  logic [SEL_W-1:0]           ldt_sel_i,
  output logic [SEL_W-1:0]           ldt_sel_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       fault_o,
  output logic                       mem_req_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  input  logic                       mem_ack_i,
  input  logic [dtr_pkg::DESC_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0]          gdt_base_o,
  output logic [LIM_W-1:0]           gdt_limit_o,
  output logic [ADDR_W-1:0]          ldt_base_o,
  output logic [LIM_W-1:0]           ldt_limit_o,
  output logic                       ldt_valid_o
);
  import dtr_pkg::*;
  localparam int unsigned IDX_W  = SEL_W - 3;
  localparam int unsigned TI_BIT = 2;

  dtr_state_e        state_q;
  logic [SEL_W-1:0]  sel_q, pend_q;
  logic [ADDR_W-1:0] addr_q, base_q;
  logic [LIM_W-1:0]  lim_q;
  logic              valid_q, done_q, fault_q;

  logic              is_null, ti_err, lim_err, desc_ok;
  logic [ADDR_W-1:0] fetch_addr, d_base;
  logic [LIM_W-1:0]  d_lim;

  dtr_gdt_reg #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_gdt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (gdt_load_i),
    .wdata_i (gdt_data_i),
    .rdata_o (gdt_data_o),
    .base_o  (gdt_base_o),
    .limit_o (gdt_limit_o)
  );

  dtr_sel_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .IDX_W(IDX_W)) u_sel (
    .idx_i       (ldt_sel_i[SEL_W-1:3]),
    .ti_i        (ldt_sel_i[TI_BIT]),
    .gdt_base_i  (gdt_base_o),
    .gdt_limit_i (gdt_limit_o),
    .is_null_o   (is_null),
    .ti_err_o    (ti_err),
    .lim_err_o   (lim_err),
    .addr_o      (fetch_addr)
  );

  dtr_desc_chk #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .LDT_TYPE(LDT_TYPE)) u_desc (
    .desc_i  (mem_rdata_i),
    .ok_o    (desc_ok),
    .base_o  (d_base),
    .limit_o (d_lim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      pend_q  <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      lim_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (ldt_load_i) begin
          if (ti_err) begin
            fault_q <= 1'b1;
          end else if (is_null) begin
            sel_q   <= ldt_sel_i;
            base_q  <= '0;
            lim_q   <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b1;
          end else if (lim_err) begin
            fault_q <= 1'b1;
          end else begin
            pend_q  <= ldt_sel_i;
            addr_q  <= fetch_addr;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_ack_i) begin
          state_q <= ST_IDLE;
          if (desc_ok) begin
            sel_q   <= pend_q;
            base_q  <= d_base;
            lim_q   <= d_lim;
            valid_q <= 1'b1;
            done_q  <= 1'b1;
          end else begin
            fault_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q == ST_FETCH);
  assign mem_req_o   = busy_o;
  assign mem_addr_o  = addr_q;
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign ldt_sel_o   = sel_q;
  assign ldt_base_o  = base_q;
  assign ldt_limit_o = lim_q;
  assign ldt_valid_o = valid_q;
endmodule

// File: rtl/dtr_unit_chk.sv
module dtr_unit_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SEL_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ldt_load_i,
  input logic [SEL_W-1:0]  ldt_sel_i,
  input logic [SEL_W-1:0]  ldt_sel_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fault_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              ldt_valid_o
);
  p_ti_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldt_load_i && !busy_o && ldt_sel_i[2]) |=> (fault_o && !mem_req_o));

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R3, R4, R6, R7: a rejected load leaves the visible selector alone
  p_fault_keeps_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($stable(ldt_sel_o) && !done_o));

  p_commit_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (ldt_sel_o[SEL_W-1:3] != '0)) |-> ldt_valid_o);

  p_null_invalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (ldt_sel_o[SEL_W-1:3] == '0)) |-> !ldt_valid_o);

  p_busy_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_ack_i) |=> ($stable(ldt_sel_o) && !done_o && !fault_o));
endmodule

bind dtr_unit dtr_unit_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ldt_load_i  (ldt_load_i),
  .ldt_sel_i   (ldt_sel_i),
  .ldt_sel_o   (ldt_sel_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .ldt_valid_o (ldt_valid_o)
);

// File: tb/dtr_unit_tb_top.sv
module dtr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        gdt_load_i = 1'b0;
  logic [39:0] gdt_data_i = '0;
  logic [39:0] gdt_data_o;
  logic        ldt_load_i = 1'b0;
  logic [15:0] ldt_sel_i = '0;
  logic [15:0] ldt_sel_o;
  logic        busy_o, done_o, fault_o, mem_req_o, mem_ack_i, ldt_valid_o;
  logic [23:0] mem_addr_o, gdt_base_o, ldt_base_o;
  logic [15:0] gdt_limit_o, ldt_limit_o;
  logic [63:0] mem_rdata_i = '0;

  int n_chk = 0;
  int n_err = 0;

  initial mem_ack_i = 1'b0;
  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dtr_unit dut_i (
    .clk_i, .rst_ni, .gdt_load_i, .gdt_data_i, .gdt_data_o,
    .ldt_load_i, .ldt_sel_i, .ldt_sel_o, .busy_o, .done_o, .fault_o,
    .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_rdata_i,
    .gdt_base_o, .gdt_limit_o, .ldt_base_o, .ldt_limit_o, .ldt_valid_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(input logic [23:0] b, input logic [15:0] l,
                                          input logic [7:0] acc);
    return {16'h0, acc, b, l};
  endfunction

  task automatic check_ldt(input string tag, input logic [15:0] sel, input logic [23:0] b,
                           input logic [15:0] l, input logic v);
    chk({tag, " sel"}, ldt_sel_o, sel);
    chk({tag, " base"}, ldt_base_o, b);
    chk({tag, " limit"}, ldt_limit_o, l);
    chk({tag, " valid"}, ldt_valid_o, v);
  endtask

  task automatic issue(input logic [15:0] sel);
    @(negedge clk_i);
    ldt_sel_i  = sel;
    ldt_load_i = 1'b1;
    @(negedge clk_i);
    ldt_load_i = 1'b0;
  endtask

  // selector check rejects: no fetch, fault pulse
  task automatic expect_reject(input string tag, input logic [15:0] sel);
    issue(sel);
    chk({tag, " fault"}, fault_o, 1'b1);
    chk({tag, " no req"}, mem_req_o, 1'b0);
  endtask

  // full fetch path; memory answers after `wait_cyc` idle cycles
  task automatic fetch(input string tag, input logic [15:0] sel, input logic [23:0] exp_addr,
                       input logic [63:0] desc, input logic ok, input int wait_cyc);
    issue(sel);
    chk({tag, " req"}, mem_req_o, 1'b1);
    chk({tag, " addr"}, mem_addr_o, exp_addr);
    for (int i = 0; i < wait_cyc; i++) begin
      @(negedge clk_i);
      chk({tag, " req held"}, mem_req_o, 1'b1);
    end
    mem_rdata_i = desc;
    mem_ack_i   = 1'b1;
    @(negedge clk_i);
    mem_ack_i = 1'b0;
    chk({tag, " done"}, done_o, ok);
    chk({tag, " fault"}, fault_o, !ok);
    chk({tag, " idle"}, busy_o, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 gdt", gdt_data_o, 40'h0);
    check_ldt("R1", 16'h0, 24'h0, 16'h0, 1'b0);
    chk("R1 busy", busy_o, 1'b0);
    chk("R1 done", done_o, 1'b0);
    chk("R1 fault", fault_o, 1'b0);
    chk("R1 req", mem_req_o, 1'b0);
  endtask

  task automatic t_gdt();
    @(negedge clk_i);
    gdt_data_i = {24'h012340, 16'h00FF};
    gdt_load_i = 1'b1;
    @(negedge clk_i);
    gdt_load_i = 1'b0;
    chk("R2 word", gdt_data_o, {24'h012340, 16'h00FF});
    chk("R2 base", gdt_base_o, 24'h012340);
    chk("R2 limit", gdt_limit_o, 16'h00FF);
  endtask

  task automatic t_good();
    fetch("R5 R8 good", 16'h0013, 24'h012340 + 24'd16, mk_desc(24'hABCDEF, 16'h0777, 8'h82), 1'b1, 3);
    check_ldt("R8", 16'h0013, 24'hABCDEF, 16'h0777, 1'b1);
  endtask

  task automatic t_ti();
    expect_reject("R3", 16'h0014);
    check_ldt("R3 unchanged", 16'h0013, 24'hABCDEF, 16'h0777, 1'b1);
  endtask

  task automatic t_limit();
    // index 31 ends at byte 0xFF == limit: accepted
    fetch("R4 edge", 16'h00FB, 24'h012340 + 24'd248, mk_desc(24'h000100, 16'h0010, 8'h82), 1'b1, 0);
    check_ldt("R4 edge", 16'h00FB, 24'h000100, 16'h0010, 1'b1);
    expect_reject("R4 over", 16'h0100);
    check_ldt("R4 unchanged", 16'h00FB, 24'h000100, 16'h0010, 1'b1);
  endtask

  task automatic t_type();
    fetch("R6 type", 16'h0008, 24'h012348, mk_desc(24'h111111, 16'h2222, 8'h83), 1'b0, 1);
    check_ldt("R6 unchanged", 16'h00FB, 24'h000100, 16'h0010, 1'b1);
  endtask

  task automatic t_present();
    fetch("R7 present", 16'h0008, 24'h012348, mk_desc(24'h111111, 16'h2222, 8'h02), 1'b0, 0);
    check_ldt("R7 unchanged", 16'h00FB, 24'h000100, 16'h0010, 1'b1);
  endtask

  task automatic t_busy();
    issue(16'h0010);
    chk("R11 req", mem_req_o, 1'b1);
    ldt_sel_i  = 16'h0018;
    ldt_load_i = 1'b1;
    @(negedge clk_i);
    ldt_load_i = 1'b0;
    chk("R11 addr kept", mem_addr_o, 24'h012350);
    mem_rdata_i = mk_desc(24'h004000, 16'h0123, 8'h82);
    mem_ack_i   = 1'b1;
    @(negedge clk_i);
    mem_ack_i = 1'b0;
    chk("R11 done", done_o, 1'b1);
    check_ldt("R11", 16'h0010, 24'h004000, 16'h0123, 1'b1);
    @(negedge clk_i);
    chk("R11 no 2nd req", mem_req_o, 1'b0);
    chk("R11 sel kept", ldt_sel_o, 16'h0010);
  endtask

  task automatic t_null();
    issue(16'h0003);
    chk("R9 done", done_o, 1'b1);
    chk("R9 no req", mem_req_o, 1'b0);
    check_ldt("R9", 16'h0003, 24'h0, 16'h0, 1'b0);
    chk("R10 rpl kept", ldt_sel_o[1:0], 2'b11);
  endtask

  task automatic t_rpl();
    fetch("R10 rpl", 16'h000A, 24'h012348, mk_desc(24'h00AA00, 16'h0055, 8'h82), 1'b1, 0);
    chk("R10 sel readback", ldt_sel_o, 16'h000A);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_gdt();
    t_good();
    t_ti();
    t_limit();
    t_type();
    t_present();
    t_busy();
    t_null();
    t_rpl();
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule